// File: doc/BRIEF.md
# Eight-Bit Addressable Latch with Mode Select

This block is a bank of eight stored bits driven by a 3-bit address, one data input, an active-low enable and an active-high clear. The two controls together pick one of four modes. In the write mode the addressed bit takes the data value. In the hold mode every bit keeps its value. In the steer mode the data goes to the addressed output and every other output is forced low. In the zero mode all bits are cleared.

Within a synchronous chip it serves two purposes. It can assemble a parallel word from a serial stream by stepping the address. It can also act as a 1-of-8 decoder whose selected line follows the data input. All updates happen on the rising edge of the system clock, so every output follows its inputs with one cycle of latency. An active-low asynchronous reset, separate from the functional clear, puts every bit at 0.

Top module: `addr_latch8`

## Requirements
- R1: While rst_ni is low, all bits of q_o are 0, independent of the clock and of the other inputs.
- R2: With en_ni=0 and clr_i=0 (write mode), at the next rising edge the bit selected by addr_i takes data_i and the other seven bits keep their values.
- R3: With en_ni=1 and clr_i=0 (hold mode), q_o does not change at the next rising edge for any addr_i or data_i.
- R4: With en_ni=0 and clr_i=1 (steer mode), at the next rising edge the selected bit takes data_i and every other bit becomes 0.
- R5: With en_ni=1 and clr_i=1 (zero mode), all bits become 0 at the next rising edge, whatever addr_i and data_i are.
- R6: Inputs are sampled only at the rising edge. A change on any input between edges leaves q_o unchanged until the next edge.
- R7: The address is binary: addr_i = k selects q_o[k], so address 0 selects q_o[0] and address 7 selects q_o[7].
- R8: A word written in steer mode is stored. It persists unchanged through later cycles in hold mode.
- R9: Eight write-mode cycles that step addr_i from 0 to 7 with the serial bits b0..b7 leave q_o equal to {b7,...,b0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Binary bit select |
| data_i | input | 1 | Serial data value |
| en_ni | input | 1 | Enable, active low |
| clr_i | input | 1 | Clear, active high |
| q_o | output | 8 | Stored parallel word |

## Verification
In steer mode two functions happen at the same edge: seven bits are cleared and the selected bit is written. A fault in either one would stay hidden if the word already held zeros. The bench therefore preloads several different words before every steer, write, hold and zero cycle, covering every address and both data values. It compares the whole word against a bench-side model after each edge. A hold cycle then follows, to show that the steered word has been stored.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;
  // encoded as {clr, en_n}
  typedef enum logic [1:0] {
    MODE_WRITE = 2'b00,
    MODE_HOLD  = 2'b01,
    MODE_STEER = 2'b10,
    MODE_ZERO  = 2'b11
  } mode_e;
endpackage

// File: rtl/al_mode_dec.sv
module al_mode_dec
  import addr_latch_pkg::*;
(
  input  logic  en_ni,
  input  logic  clr_i,
  output mode_e mode_o
);
  always_comb begin
    unique case ({clr_i, en_ni})
      2'b00:   mode_o = MODE_WRITE;
      2'b01:   mode_o = MODE_HOLD;
      2'b10:   mode_o = MODE_STEER;
      default: mode_o = MODE_ZERO;
    endcase
  end
endmodule

// File: rtl/al_addr_dec.sv
module al_addr_dec #(
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned NB    = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NB-1:0]     sel_o
);
  for (genvar k = 0; k < NB; k++) begin : g_sel
    assign sel_o[k] = (addr_i == ADDR_W'(k));
  end
endmodule

// File: rtl/al_bit.sv
module al_bit
  import addr_latch_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  logic  sel_i,
  input  logic  d_i,
  output logic  q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= 1'b0;
    end else begin
      unique case (mode_i)
        MODE_WRITE: if (sel_i) q_o <= d_i;
        MODE_HOLD:  q_o <= q_o;
        MODE_STEER: q_o <= sel_i & d_i;
        default:    q_o <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/addr_latch8.sv
module addr_latch8
  import addr_latch_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned NB    = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_i,
  input  logic              en_ni,
  input  logic              clr_i,
  output logic [NB-1:0]     q_o
);
  mode_e          mode;
  logic  [NB-1:0] sel;

  al_mode_dec u_mode (
    .en_ni (en_ni),
    .clr_i (clr_i),
    .mode_o(mode)
  );

  al_addr_dec #(.ADDR_W(ADDR_W)) u_addr (
    .addr_i(addr_i),
    .sel_o (sel)
  );

  for (genvar k = 0; k < NB; k++) begin : g_bit
    al_bit u_bit (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .mode_i(mode),
      .sel_i (sel[k]),
      .d_i   (data_i),
      .q_o   (q_o[k])
    );
  end
endmodule

// File: rtl/addr_latch8_chk.sv
module addr_latch8_chk #(
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned NB    = 1 << ADDR_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              data_i,
  input logic              en_ni,
  input logic              clr_i,
  input logic [NB-1:0]     q_o
);
  logic [NB-1:0] mask;
  assign mask = NB'(1) << addr_i;

  // R2: addressed bit written, rest kept
  a_r2_write_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_ni && !clr_i) |=> ((q_o & $past(mask)) == ($past(data_i) ? $past(mask) : '0)));
  a_r2_write_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_ni && !clr_i) |=> (((q_o ^ $past(q_o)) & ~$past(mask)) == '0));
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_ni && !clr_i) |=> $stable(q_o));
  a_r4_steer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_ni && clr_i) |=> (q_o == ($past(data_i) ? $past(mask) : '0)));
  a_r4_steer_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_ni && clr_i) |=> $onehot0(q_o));
  a_r5_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_ni && clr_i) |=> (q_o == '0));
endmodule

bind addr_latch8 addr_latch8_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .addr_i(addr_i),
  .data_i(data_i),
  .en_ni (en_ni),
  .clr_i (clr_i),
  .q_o   (q_o)
);

// File: tb/sim_addr_latch8.sv
`timescale 1ns/1ps
module sim_addr_latch8;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic       data_i = 1'b0;
  logic       en_ni = 1'b1;
  logic       clr_i = 1'b0;
  logic [7:0] q_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] model = '0;

  always #4 clk_i = ~clk_i;

  addr_latch8 u0 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .addr_i(addr_i),
    .data_i(data_i),
    .en_ni (en_ni),
    .clr_i (clr_i),
    .q_o   (q_o)
  );

  task automatic check(input string tag, input logic [7:0] exp);
    total++;
    if (q_o !== exp) begin
      bad++;
      $display("FAIL %s q=%h exp=%h", tag, q_o, exp);
    end
  endtask

  // one cycle: drive at negedge, confirm no early change, check after edge
  task automatic step(input logic en, input logic clr, input logic [2:0] a, input logic d);
    string tag;
    @(negedge clk_i);
    en_ni = en; clr_i = clr; addr_i = a; data_i = d;
    #1 check("R6", model);
    @(posedge clk_i);
    #1;
    unique case ({clr, en})
      2'b00: begin model[a] = d; tag = "R2"; end
      2'b01: tag = "R3";
      2'b10: begin model = d ? (8'd1 << a) : 8'd0; tag = "R4"; end
      default: begin model = '0; tag = "R5"; end
    endcase
    check(tag, model);
  endtask

  task automatic load(input logic [7:0] w);
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 3'(i), w[i]);
  endtask

  initial begin
    #150000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog q=%h exp=%h", q_o, model);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] pre [4];
    pre[0] = 8'h00; pre[1] = 8'hFF; pre[2] = 8'h5A; pre[3] = 8'hC3;

    // R1: reset state while clock runs
    repeat (3) @(posedge clk_i);
    #1 check("R1", 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R9: serial to parallel
    load(8'hA5);
    step(1'b1, 1'b0, 3'd2, 1'b0);
    check("R9", 8'hA5);

    // R7: address k selects q_o[k]
    step(1'b1, 1'b1, 3'd0, 1'b0);
    step(1'b0, 1'b0, 3'd3, 1'b1);
    check("R7", 8'h08);
    step(1'b0, 1'b0, 3'd7, 1'b1);
    check("R7", 8'h88);
    step(1'b0, 1'b0, 3'd0, 1'b1);
    check("R7", 8'h89);

    // exhaustive sweep: preload x mode x address x data
    for (int p = 0; p < 4; p++)
      for (int m = 0; m < 4; m++)
        for (int a = 0; a < 8; a++)
          for (int d = 0; d < 2; d++) begin
            logic [7:0] after;
            load(pre[p]);
            step(m[0], m[1], 3'(a), d[0]);
            after = model;
            step(1'b1, 1'b0, 3'(7 - a), ~d[0]);
            step(1'b1, 1'b0, 3'(a), d[0]);
            if (m == 2) check("R8", after);
          end

    // R1: asynchronous reset mid-run
    load(8'hF0);
    @(negedge clk_i);
    en_ni = 1'b1; clr_i = 1'b0;
    #1 rst_ni = 1'b0;
    #1 check("R1", 8'h00);
    model = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1'b1, 1'b0, 3'd0, 1'b0);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule